// File: doc/BRIEF.md
# Variable-Length Synchronous Serial Master

This block is a synchronous serial master for SPI-style lines. When it is idle and sees a start strobe, it takes in a parallel character of 5 to 9 bits and drives one select line low. It then toggles a divided serial clock, shifts the character out most significant bit first, and shifts in a character from the receive line at the same time. No framing bits are added. A one-cycle done pulse reports the end of the exchange, and the received character is shown in that same cycle.

The length, the clock polarity and the clock phase come from configuration inputs, and so does the serial clock half-period, counted in system clocks. Software keeps these inputs stable between transfers. The phase bit uses an inverted convention: phase 1 samples on the leading edge, and phase 0 samples on the trailing edge. Together, polarity and phase give four mutually incompatible modes. Mode 0 is polarity 0 with phase 1. Mode 1 is polarity 0 with phase 0. Mode 2 is polarity 1 with phase 1. Mode 3 is polarity 1 with phase 0.

Top module: `spi_char_master`

## Requirements
- R1: The character length is taken from `cfg_len_sel` when `start` is accepted. Code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. When `cfg_len9` is 1, the length is 9 whatever `cfg_len_sel` holds.
- R2: `mosi` carries the low N bits of `tx_char`, MSB (bit N-1) first. Bits of `tx_char` at or above N are ignored. A transfer has exactly 2N serial clock edges, with no start, parity or stop bit.
- R3: `rx_char` holds the N bits sampled from `miso`. The first sampled bit lands in bit N-1. Bits N and above read as zero.
- R4: While `sel_n` is high, `sclk` rests at the level of `cfg_cpol`.
- R5: With `cfg_cpha`=1, the MSB is on `mosi` before the first edge. `miso` is sampled on leading edges (edges moving away from the idle level), and `mosi` changes on trailing edges.
- R6: With `cfg_cpha`=0, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R7: The serial clock half-period is `cfg_half_div` system clocks. A value of 0 acts as 1.
- R8: `sel_n` falls on the clock edge that accepts `start`. The first `sclk` edge comes one half-period later. `sel_n` rises one half-period after the last edge.
- R9: A `start` that arrives while `sel_n` is low is ignored. It starts no new transfer and does not change the bits being shifted.
- R10: `done` is high for exactly one system clock per transfer. It rises on the edge at which the final bit is sampled (edge 2N-1 for phase 1, edge 2N for phase 0), and `rx_char` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_sel | input | 2 | Character length code (5 to 8 bits) |
| cfg_len9 | input | 1 | Forces a 9-bit character |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 1: sample on leading edge, 0: sample on trailing edge |
| cfg_half_div | input | DIV_W | Half-period in system clocks (0 acts as 1) |
| start | input | 1 | Start strobe, accepted only when idle |
| tx_char | input | 9 | Character to send, right-aligned |
| miso | input | 1 | Serial receive data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial transmit data |
| sel_n | output | 1 | Active-low select |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_char | output | 9 | Received character, right-aligned |

## Verification
A start strobe and the done pulse can fall in the same system clock. The master is still inside its frame at that point, because its trailing edge or its closing half-period has not yet passed. The bench provokes this by waiting for `done` and raising `start` in that very cycle with a different character. It judges the outcome in three ways: the scoreboard must receive no extra result, the slave model must have received the original character intact, and `sel_n` must stay high once the frame has closed.

// File: rtl/spi_char_pkg.sv
package spi_char_pkg;
  localparam int CHAR_MAX = 9;
  localparam int NB_W     = $clog2(CHAR_MAX + 1);
  localparam int EDGE_W   = NB_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_TAIL
  } xfer_state_t;

  typedef struct packed {
    logic [NB_W-1:0] nbits;
    logic            cpha;
  } xfer_cfg_t;

  function automatic logic [NB_W-1:0] decode_len(input logic [1:0] code, input logic force9);
    if (force9) return NB_W'(CHAR_MAX);
    return NB_W'(5) + NB_W'(code);
  endfunction
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, reload;
  logic             cnt_en;

  always_comb begin
    reload = (half_div == '0) ? '0 : half_div - 1'b1;
    tick   = run && (cnt_q == '0);
    cnt_en = load || run;
    cnt_d  = cnt_q;
    if (load || tick) cnt_d = reload;
    else if (run)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_char_pkg::*;
#(
  parameter int W = CHAR_MAX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            load_cpha,
  input  logic [NB_W-1:0] load_nbits,
  input  logic [W-1:0]    tx_char,
  input  logic            shift_en,
  input  logic            sample_en,
  input  logic            miso,
  output logic            mosi,
  output logic [W-1:0]    rx_next
);
  logic [W:0]   tx_q, tx_d;
  logic [W-1:0] rx_q, rx_d, tx_al;
  logic         tx_en, rx_en;

  always_comb begin
    tx_al   = tx_char << (NB_W'(W) - load_nbits);
    rx_next = {rx_q[W-2:0], miso};
    tx_en   = load || shift_en;
    rx_en   = load || sample_en;
    if (load) tx_d = load_cpha ? {tx_al, 1'b0} : {1'b0, tx_al};
    else      tx_d = {tx_q[W-1:0], 1'b0};
    rx_d    = load ? '0 : rx_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (tx_en) tx_q <= tx_d;
      if (rx_en) rx_q <= rx_d;
    end
  end

  assign mosi = tx_q[W];
endmodule

// File: rtl/spi_char_master.sv
module spi_char_master
  import spi_char_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_len_sel,
  input  logic                cfg_len9,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic [DIV_W-1:0]    cfg_half_div,
  input  logic                start,
  input  logic [CHAR_MAX-1:0] tx_char,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                sel_n,
  output logic                done,
  output logic [CHAR_MAX-1:0] rx_char
);
  logic [1:0]          rst_sync_q;
  logic                rst_i;
  xfer_state_t         state_q, state_d;
  logic [EDGE_W-1:0]   ecnt_q, ecnt_d, last_idx;
  xfer_cfg_t           cfg_q, cfg_d;
  logic                sclk_q, sclk_d, sel_q, sel_d, done_q;
  logic [CHAR_MAX-1:0] rx_q, rx_next;
  logic                accept, tick, edge_go, leading;
  logic                sample_en, shift_en, final_sample;
  logic [NB_W-1:0]     new_nbits;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (accept),
    .run      (state_q != ST_IDLE),
    .half_div (cfg_half_div),
    .tick     (tick)
  );

  spi_shift_unit #(.W(CHAR_MAX)) u_shift (
    .clk        (clk),
    .rst_n      (rst_i),
    .load       (accept),
    .load_cpha  (cfg_cpha),
    .load_nbits (new_nbits),
    .tx_char    (tx_char),
    .shift_en   (shift_en),
    .sample_en  (sample_en),
    .miso       (miso),
    .mosi       (mosi),
    .rx_next    (rx_next)
  );

  always_comb begin
    new_nbits    = decode_len(cfg_len_sel, cfg_len9);
    accept       = start && (state_q == ST_IDLE);
    edge_go      = tick && ((state_q == ST_LEAD) || (state_q == ST_RUN));
    leading      = ~ecnt_q[0];
    sample_en    = edge_go && (leading == cfg_q.cpha);
    shift_en     = edge_go && (leading != cfg_q.cpha);
    last_idx     = {cfg_q.nbits, 1'b0} - 1'b1;
    final_sample = sample_en && (ecnt_q[EDGE_W-1:1] == cfg_q.nbits - 1'b1);
  end

  always_comb begin
    state_d = state_q;
    ecnt_d  = ecnt_q;
    cfg_d   = cfg_q;
    sclk_d  = sclk_q;
    sel_d   = sel_q;
    unique case (state_q)
      ST_IDLE: begin
        sclk_d = cfg_cpol;
        if (start) begin
          state_d     = ST_LEAD;
          sel_d       = 1'b0;
          ecnt_d      = '0;
          cfg_d.nbits = new_nbits;
          cfg_d.cpha  = cfg_cpha;
        end
      end
      ST_LEAD, ST_RUN: begin
        if (tick) begin
          sclk_d  = ~sclk_q;
          ecnt_d  = ecnt_q + 1'b1;
          state_d = (ecnt_q == last_idx) ? ST_TAIL : ST_RUN;
        end
      end
      ST_TAIL: begin
        if (tick) begin
          state_d = ST_IDLE;
          sel_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      ecnt_q  <= '0;
      cfg_q   <= '0;
      sclk_q  <= 1'b0;
      sel_q   <= 1'b1;
      done_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      cfg_q   <= cfg_d;
      sclk_q  <= sclk_d;
      sel_q   <= sel_d;
      done_q  <= final_sample;
      if (final_sample) rx_q <= rx_next;
    end
  end

  assign sclk    = sclk_q;
  assign sel_n   = sel_q;
  assign done    = done_q;
  assign rx_char = rx_q;
endmodule

// File: rtl/spi_char_master_chk.sv
module spi_char_master_chk (
  input logic clk,
  input logic rst_ok,
  input logic cfg_cpol,
  input logic sclk,
  input logic sel_n,
  input logic done
);
  // R10: done lasts one system clock
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !done);

  // R10: done only inside a frame
  assert_done_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    done |-> !sel_n);

  // R4: idle level follows polarity
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (sel_n && $past(sel_n) && $past(rst_ok) && $stable(cfg_cpol)) |-> (sclk == cfg_cpol));

  // R8: select falls while the clock still rests
  assert_sel_lead_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(sel_n) |-> (sclk == cfg_cpol));

  // R8: select release comes after the done pulse has ended
  assert_release_after_done_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(sel_n) |-> !done);
endmodule

bind spi_char_master spi_char_master_chk u_chk (
  .clk      (clk),
  .rst_ok   (rst_i),
  .cfg_cpol (cfg_cpol),
  .sclk     (sclk),
  .sel_n    (sel_n),
  .done     (done)
);

// File: tb/spi_char_master_test.sv
module spi_char_master_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_len_sel;
  logic       cfg_len9, cfg_cpol, cfg_cpha, start, miso;
  logic [7:0] cfg_half_div;
  logic [8:0] tx_char, rx_char;
  logic       sclk, mosi, sel_n, done;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  logic [8:0] exp_rx_q[$];
  int         cur_n = 5, cur_h = 1;
  logic       cur_cpol = 1'b0, cur_cpha = 1'b0;
  logic [8:0] slv_word = '0, slv_sh = '0, slv_got = '0, exp_mosi_w = '0;
  int         edges = 0, t_sel_fall = 0, t_first = 0, t_last = 0, t_rise = 0, done_cnt = 0;

  spi_char_master #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_len_sel(cfg_len_sel), .cfg_len9(cfg_len9),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_half_div(cfg_half_div),
    .start(start), .tx_char(tx_char), .miso(miso), .sclk(sclk), .mosi(mosi),
    .sel_n(sel_n), .done(done), .rx_char(rx_char)
  );

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model
  always @(negedge sel_n) begin
    edges   = 0;
    slv_got = '0;
    slv_sh  = slv_word << (9 - cur_n);
    t_sel_fall = cyc;
    if (cur_cpha) miso = slv_sh[8];
  end

  always @(posedge sel_n) t_rise = cyc;

  always @(sclk) begin
    if (!sel_n) begin
      edges++;
      if (edges == 1) t_first = cyc;
      t_last = cyc;
      if ((sclk != cur_cpol) == cur_cpha) slv_got = {slv_got[7:0], mosi};
      else if (cur_cpha) begin
        slv_sh = slv_sh << 1;
        miso   = slv_sh[8];
      end else begin
        miso   = slv_sh[8];
        slv_sh = slv_sh << 1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (done && rst_n) begin
      done_cnt++;
      if (exp_rx_q.size() == 0) begin
        chk(1'b0, "R9 unexpected result", rx_char, 0);
      end else begin
        logic [8:0] e;
        e = exp_rx_q.pop_front();
        chk(rx_char == e, "R3 rx_char", rx_char, e);
        chk(edges == (cur_cpha ? 2*cur_n-1 : 2*cur_n), "R10 done edge", edges,
            cur_cpha ? 2*cur_n-1 : 2*cur_n);
      end
    end
  end

  task automatic run_xfer(input logic [1:0] len, input logic nine, input logic pol,
                          input logic pha, input logic [7:0] hdiv, input logic [8:0] txw,
                          input logic [8:0] sw, input bit poke);
    logic [8:0] mask;
    @(negedge clk);
    cfg_len_sel = len; cfg_len9 = nine; cfg_cpol = pol; cfg_cpha = pha; cfg_half_div = hdiv;
    cur_n = nine ? 9 : 5 + int'(len);
    cur_h = (hdiv == 0) ? 1 : int'(hdiv);
    cur_cpol = pol; cur_cpha = pha;
    mask = 9'h1FF >> (9 - cur_n);
    exp_mosi_w = txw & mask;
    slv_word = sw;
    exp_rx_q.push_back(sw & mask);
    done_cnt = 0;
    repeat (2) @(negedge clk);
    chk(sclk == pol, "R4 idle level", sclk, pol);
    tx_char = txw; start = 1'b1;
    @(negedge clk);
    start = 1'b0; tx_char = ~txw;
    if (pha) chk(mosi == exp_mosi_w[cur_n-1], "R5 first bit early", mosi, exp_mosi_w[cur_n-1]);
    if (poke) begin
      while (!done) @(negedge clk);
      start = 1'b1; tx_char = 9'h0AA;
      @(negedge clk);
      start = 1'b0;
    end
    while (!sel_n) @(negedge clk);
    repeat (cur_h + 3) @(negedge clk);
    chk(slv_got == exp_mosi_w, pha ? "R2 R5 mosi word" : "R2 R6 mosi word", slv_got, exp_mosi_w);
    chk(edges == 2*cur_n, "R1 R2 edge count", edges, 2*cur_n);
    chk(t_first - t_sel_fall == cur_h, "R7 R8 lead time", t_first - t_sel_fall, cur_h);
    chk(t_rise - t_last == cur_h, "R8 tail time", t_rise - t_last, cur_h);
    chk(done_cnt == 1, "R10 done count", done_cnt, 1);
    chk(exp_rx_q.size() == 0, "R10 missing result", exp_rx_q.size(), 0);
    chk(sel_n == 1'b1, "R9 no restart", sel_n, 1);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; miso = 1'b0; tx_char = '0;
    cfg_len_sel = 2'd0; cfg_len9 = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_half_div = 8'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sel_n == 1'b1, "R8 reset sel_n", sel_n, 1);
    chk(done == 1'b0, "R10 reset done", done, 0);
    chk(sclk == 1'b0, "R4 reset sclk", sclk, 0);
    chk(rx_char == 9'h000, "R3 reset rx_char", rx_char, 0);

    run_xfer(2'd0, 1'b0, 1'b0, 1'b1, 8'd1, 9'h1F5, 9'h013, 1'b0); // R1 5 bits, mode 0
    run_xfer(2'd1, 1'b0, 1'b0, 1'b0, 8'd2, 9'h0E9, 9'h1D6, 1'b0); // R6 mode 1
    run_xfer(2'd2, 1'b0, 1'b1, 1'b1, 8'd3, 9'h155, 9'h02A, 1'b0); // R5 mode 2
    run_xfer(2'd3, 1'b0, 1'b1, 1'b0, 8'd0, 9'h1C3, 9'h15A, 1'b0); // R7 zero divider, mode 3
    run_xfer(2'd0, 1'b1, 1'b0, 1'b1, 8'd4, 9'h1A5, 9'h14B, 1'b0); // R1 nine overrides code
    run_xfer(2'd3, 1'b1, 1'b1, 1'b0, 8'd1, 9'h101, 9'h180, 1'b1); // R9 start during done
    run_xfer(2'd3, 1'b0, 1'b0, 1'b1, 8'd2, 9'h0FF, 9'h000, 1'b1); // R9 phase 1
    run_xfer(2'd2, 1'b0, 1'b0, 1'b0, 8'd5, 9'h000, 9'h07F, 1'b0); // R3 all ones
    run_xfer(2'd1, 1'b0, 1'b1, 1'b1, 8'd1, 9'h13C, 9'h1E1, 1'b0); // R2 upper bits ignored

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule